// File: doc/BRIEF.md
# Monitor Result Serial Transmitter

This block sends the results of a two-channel signal monitor over a three-wire serial link. The wires are a divided serial clock, a frame marker and one data line. The measurement engine delivers a complete result set with a one-cycle valid strobe. A set holds a 20-bit mean-square/root-mean-square word, a 13-bit peak word and a 13-bit threshold-count word for channel A and for channel B. The transmitter keeps the set and shifts the enabled words out as one frame.

Plain control pins set the behaviour:
- a master enable;
- one enable for each measurement kind;
- a 2-bit divide code for the serial clock;
- a sleep bit that parks the serial clock low when there is nothing to send.

The result input has a valid strobe and no ready signal, so the transmitter never applies back-pressure. Every strobe seen while the master enable is high is accepted at once. One result set can wait behind the frame in flight. A later strobe replaces the waiting set, so the receiver always gets the newest result and never a backlog.

Top module: `monres_serial_tx`

## Requirements
- R1: The divide code sets the serial clock period in input clock cycles. Codes 00 and 01 give 2 cycles, code 10 gives 4 cycles and code 11 gives 8 cycles. The high and low halves are equal.
- R2: With sleep set, the serial clock stays low whenever no frame is being sent and no result set is waiting.
- R3: With sleep clear and the master enable high, the serial clock toggles continuously, including when there is no data.
- R4: Taking the master enable low has these effects:
  - serial clock, frame marker and data go low within one cycle;
  - any frame in progress is abandoned;
  - any waiting set is discarded;
  - result strobes seen while the enable is low are ignored.
- R5: A frame has this layout:
  - the frame marker is high for exactly one serial clock period (one rising edge), with data low;
  - the enabled words follow, MSB first, in the order: mean-square A, mean-square B, peak A, peak B, threshold A, threshold B;
  - a disabled kind is left out of the frame for both channels;
  - word widths are 20, 20, 13, 13, 13 and 13 bits.
- R6: The frame marker and data change only at the input clock edge where the serial clock falls. They are steady while the serial clock is high.
- R7: A result set that arrives during a frame is sent right after that frame. If several arrive, only the last one is sent.
- R8: If all three kind enables are clear when a frame would start, no frame is sent and the waiting set is discarded.
- R9: After reset, serial clock, frame marker and data are low, and no frame is sent until a result set arrives.
- R10: A result strobe may arrive in the same cycle that a waiting set is moved into the shifter. In that case the frame carries the earlier set and the new set waits for the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Master enable for the serial output |
| en_msq | input | 1 | Include the mean-square words |
| en_peak | input | 1 | Include the peak words |
| en_thr | input | 1 | Include the threshold words |
| div_sel | input | 2 | Serial clock divide code |
| sleep_en | input | 1 | Park the serial clock low when idle |
| res_valid | input | 1 | One-cycle strobe: the result words are valid |
| msq_a | input | 20 | Mean-square result, channel A |
| msq_b | input | 20 | Mean-square result, channel B |
| peak_a | input | 13 | Peak result, channel A |
| peak_b | input | 13 | Peak result, channel B |
| thr_a | input | 13 | Threshold result, channel A |
| thr_b | input | 13 | Threshold result, channel B |
| ser_clk | output | 1 | Divided serial clock |
| ser_sync | output | 1 | Frame marker |
| ser_data | output | 1 | Serial data |

## Verification
Two events can fall in the same input cycle: a result strobe and the frame boundary at which the waiting set is moved into the shifter. The bench provokes this by strobing a new, index-tagged set on every cycle for several hundred cycles at the fastest divide. Every boundary then coincides with a strobe. Each received frame is decoded by its tag and compared with the set generated for that tag. Tags must rise strictly from frame to frame, and the last frame must carry the last set sent, so neither a lost set nor a torn frame passes.

// File: rtl/monres_pkg.sv
package monres_pkg;

  localparam int MSQ_W   = 20;
  localparam int PEAK_W  = 13;
  localparam int THR_W   = 13;
  localparam int FRAME_W = 2 * (MSQ_W + PEAK_W + THR_W);
  localparam int LEN_W   = $clog2(FRAME_W + 1);
  localparam int HALF_MAX = 4;
  localparam int DCNT_W  = $clog2(HALF_MAX);

  typedef struct packed {
    logic [MSQ_W-1:0]  msq_a;
    logic [MSQ_W-1:0]  msq_b;
    logic [PEAK_W-1:0] peak_a;
    logic [PEAK_W-1:0] peak_b;
    logic [THR_W-1:0]  thr_a;
    logic [THR_W-1:0]  thr_b;
  } res_set_t;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_SYNC = 2'd1,
    FR_DATA = 2'd2
  } fr_state_e;

  // input clock cycles per serial clock half period
  function automatic logic [DCNT_W:0] half_cycles(input logic [1:0] code);
    case (code)
      2'b10:   half_cycles = (DCNT_W+1)'(2);
      2'b11:   half_cycles = (DCNT_W+1)'(4);
      default: half_cycles = (DCNT_W+1)'(1);
    endcase
  endfunction

endpackage

// File: rtl/monres_sclk_gen.sv
module monres_sclk_gen
  import monres_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] div_sel,
  output logic       sclk,
  output logic       fall_stb
);

  logic [DCNT_W-1:0] cnt_q;
  logic              sclk_q;
  logic [DCNT_W:0]   half;
  logic              toggle;

  assign half     = half_cycles(div_sel);
  assign toggle   = run && ({1'b0, cnt_q} >= (half - 1'b1));
  assign fall_stb = toggle && sclk_q;
  assign sclk     = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (toggle) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // clock parks low as soon as it is not allowed to run
  assert_park_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !sclk_q);

  // at the fastest divide the clock changes on every cycle while running
  assert_fast_toggle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && div_sel[1] == 1'b0) |=> (sclk_q != $past(sclk_q)));

endmodule

// File: rtl/monres_pend_hold.sv
module monres_pend_hold
  import monres_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     port_en,
  input  logic     in_valid,
  input  res_set_t in_set,
  input  logic     take,
  output logic     pend,
  output res_set_t held_set
);

  logic     pend_q;
  res_set_t set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      set_q  <= '0;
    end else if (!port_en) begin
      pend_q <= 1'b0;
    end else if (in_valid) begin
      // newest set wins, even when the old one is consumed this cycle
      pend_q <= 1'b1;
      set_q  <= in_set;
    end else if (take) begin
      pend_q <= 1'b0;
    end
  end

  assign pend     = pend_q;
  assign held_set = set_q;

  assert_keep_latest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && in_valid) |=> (pend_q && set_q == $past(in_set)));

  assert_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && in_valid && take) |=> pend_q);

  assert_drop_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !pend_q);

endmodule

// File: rtl/monres_framer.sv
module monres_framer
  import monres_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     port_en,
  input  logic     fall_stb,
  input  logic     pend,
  input  res_set_t held_set,
  input  logic     en_msq,
  input  logic     en_peak,
  input  logic     en_thr,
  output logic     take,
  output logic     busy,
  output logic     fsync,
  output logic     sdata
);

  typedef logic [FRAME_W-1:0] frame_t;

  fr_state_e        st_q;
  frame_t           sh_q;
  logic [LEN_W-1:0] left_q;
  logic             fs_q;
  logic             sd_q;

  frame_t           acc;
  frame_t           packed_frame;
  logic [LEN_W-1:0] len;
  logic             any_en;
  logic             boundary;
  logic             start;

  assign any_en = en_msq || en_peak || en_thr;

  // right-aligned concatenation of enabled words, then aligned to the MSB
  always_comb begin
    acc = '0;
    len = '0;
    if (en_msq) begin
      acc = (acc << MSQ_W) | FRAME_W'(held_set.msq_a);
      acc = (acc << MSQ_W) | FRAME_W'(held_set.msq_b);
      len = len + LEN_W'(2 * MSQ_W);
    end
    if (en_peak) begin
      acc = (acc << PEAK_W) | FRAME_W'(held_set.peak_a);
      acc = (acc << PEAK_W) | FRAME_W'(held_set.peak_b);
      len = len + LEN_W'(2 * PEAK_W);
    end
    if (en_thr) begin
      acc = (acc << THR_W) | FRAME_W'(held_set.thr_a);
      acc = (acc << THR_W) | FRAME_W'(held_set.thr_b);
      len = len + LEN_W'(2 * THR_W);
    end
    packed_frame = acc << (LEN_W'(FRAME_W) - len);
  end

  assign boundary = (st_q == FR_IDLE) || (st_q == FR_DATA && left_q == '0);
  assign take     = fall_stb && boundary && pend;
  assign start    = take && any_en;
  assign busy     = (st_q != FR_IDLE);
  assign fsync    = fs_q;
  assign sdata    = sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_IDLE;
      sh_q   <= '0;
      left_q <= '0;
      fs_q   <= 1'b0;
      sd_q   <= 1'b0;
    end else if (!port_en) begin
      st_q   <= FR_IDLE;
      left_q <= '0;
      fs_q   <= 1'b0;
      sd_q   <= 1'b0;
    end else if (fall_stb) begin
      if (boundary) begin
        if (start) begin
          st_q   <= FR_SYNC;
          fs_q   <= 1'b1;
          sd_q   <= 1'b0;
          sh_q   <= packed_frame;
          left_q <= len - 1'b1;
        end else begin
          st_q   <= FR_IDLE;
          fs_q   <= 1'b0;
          sd_q   <= 1'b0;
        end
      end else if (st_q == FR_SYNC) begin
        st_q <= FR_DATA;
        fs_q <= 1'b0;
        sd_q <= sh_q[FRAME_W-1];
        sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
      end else begin
        sd_q   <= sh_q[FRAME_W-1];
        sh_q   <= {sh_q[FRAME_W-2:0], 1'b0};
        left_q <= left_q - 1'b1;
      end
    end
  end

  assert_sync_one_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && fs_q && fall_stb) |=> !fs_q);

  assert_start_needs_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs_q) |-> $past(any_en));

  assert_change_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && !fall_stb) |=> ($stable(sd_q) && $stable(fs_q)));

endmodule

// File: rtl/monres_serial_tx.sv
module monres_serial_tx
  import monres_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              en_msq,
  input  logic              en_peak,
  input  logic              en_thr,
  input  logic [1:0]        div_sel,
  input  logic              sleep_en,
  input  logic              res_valid,
  input  logic [MSQ_W-1:0]  msq_a,
  input  logic [MSQ_W-1:0]  msq_b,
  input  logic [PEAK_W-1:0] peak_a,
  input  logic [PEAK_W-1:0] peak_b,
  input  logic [THR_W-1:0]  thr_a,
  input  logic [THR_W-1:0]  thr_b,
  output logic              ser_clk,
  output logic              ser_sync,
  output logic              ser_data
);

  res_set_t in_set;
  res_set_t held_set;
  logic     pend;
  logic     take;
  logic     busy;
  logic     run;
  logic     fall_stb;

  assign in_set = '{msq_a: msq_a, msq_b: msq_b, peak_a: peak_a,
                    peak_b: peak_b, thr_a: thr_a, thr_b: thr_b};

  assign run = port_en && (!sleep_en || busy || pend);

  monres_sclk_gen u_sclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .div_sel  (div_sel),
    .sclk     (ser_clk),
    .fall_stb (fall_stb)
  );

  monres_pend_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .in_valid (res_valid),
    .in_set   (in_set),
    .take     (take),
    .pend     (pend),
    .held_set (held_set)
  );

  monres_framer u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .port_en  (port_en),
    .fall_stb (fall_stb),
    .pend     (pend),
    .held_set (held_set),
    .en_msq   (en_msq),
    .en_peak  (en_peak),
    .en_thr   (en_thr),
    .take     (take),
    .busy     (busy),
    .fsync    (ser_sync),
    .sdata    (ser_data)
  );

  assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (!ser_clk && !ser_sync && !ser_data));

  assert_idle_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_en && !busy && !pend && !ser_clk) |=> !ser_clk);

endmodule

// File: tb/monres_serial_tx_test.sv
module monres_serial_tx_test;

  localparam int FW = 2 * (20 + 13 + 13);

  typedef struct {
    logic [19:0] msa, msb;
    logic [12:0] pka, pkb, tha, thb;
  } bset_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, port_en, en_msq, en_peak, en_thr, sleep_en, res_valid;
  logic [1:0] div_sel;
  logic [19:0] msq_a, msq_b;
  logic [12:0] peak_a, peak_b, thr_a, thr_b;
  logic ser_clk, ser_sync, ser_data;

  monres_serial_tx uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .en_msq(en_msq),
    .en_peak(en_peak), .en_thr(en_thr), .div_sel(div_sel),
    .sleep_en(sleep_en), .res_valid(res_valid), .msq_a(msq_a),
    .msq_b(msq_b), .peak_a(peak_a), .peak_b(peak_b), .thr_a(thr_a),
    .thr_b(thr_b), .ser_clk(ser_clk), .ser_sync(ser_sync),
    .ser_data(ser_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // serial receiver model
  int rise_cnt = 0, sync_cnt = 0, last_rise = 0, last_period = 0;
  int r6_viol = 0, nb = 0, nfr = 0, exp_len = FW;
  bit collecting = 0;
  logic [FW-1:0] rbuf;
  logic [FW-1:0] frames [0:63];
  logic p_clk = 0, p_fs = 0, p_sd = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ser_clk && p_clk && (ser_sync != p_fs || ser_data != p_sd)) r6_viol++;
      if (ser_clk && !p_clk) begin
        rise_cnt++;
        last_period = cyc - last_rise;
        last_rise = cyc;
        if (ser_sync) begin
          sync_cnt++;
          collecting = 1;
          nb = 0;
          rbuf = '0;
        end else if (collecting) begin
          rbuf[FW-1-nb] = ser_data;
          nb++;
          if (nb == exp_len) begin
            if (nfr < 64) frames[nfr] = rbuf;
            nfr++;
            collecting = 0;
          end
        end
      end
    end
    p_clk = ser_clk; p_fs = ser_sync; p_sd = ser_data;
  end

  function automatic bset_t gen_set(input int unsigned idx);
    bset_t s;
    s.msa = idx[19:0];
    s.msb = 20'(idx * 32'h9E37 + 32'd7);
    s.pka = 13'(idx * 32'd77 + 32'd3);
    s.pkb = 13'(idx * 32'd1031 + 32'h155);
    s.tha = 13'(idx ^ 32'h0AAA);
    s.thb = 13'(idx * 32'd5 + 32'h1234);
    return s;
  endfunction

  function automatic logic [FW-1:0] expect_frame(input bset_t s, input bit m,
                                                 input bit p, input bit t);
    logic [FW-1:0] v = '0;
    int pos = FW - 1;
    if (m) begin
      for (int i = 19; i >= 0; i--) begin v[pos] = s.msa[i]; pos--; end
      for (int i = 19; i >= 0; i--) begin v[pos] = s.msb[i]; pos--; end
    end
    if (p) begin
      for (int i = 12; i >= 0; i--) begin v[pos] = s.pka[i]; pos--; end
      for (int i = 12; i >= 0; i--) begin v[pos] = s.pkb[i]; pos--; end
    end
    if (t) begin
      for (int i = 12; i >= 0; i--) begin v[pos] = s.tha[i]; pos--; end
      for (int i = 12; i >= 0; i--) begin v[pos] = s.thb[i]; pos--; end
    end
    return v;
  endfunction

  function automatic int len_of(input bit m, input bit p, input bit t);
    return (m ? 40 : 0) + (p ? 26 : 0) + (t ? 26 : 0);
  endfunction

  function automatic int period_of(input logic [1:0] code);
    return (code == 2'b10) ? 4 : (code == 2'b11) ? 8 : 2;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_en(input bit m, input bit p, input bit t);
    en_msq = m; en_peak = p; en_thr = t;
    exp_len = len_of(m, p, t);
  endtask

  task automatic drive_set(input bset_t s);
    msq_a = s.msa; msq_b = s.msb; peak_a = s.pka;
    peak_b = s.pkb; thr_a = s.tha; thr_b = s.thb;
  endtask

  task automatic send(input bset_t s);
    @(negedge clk);
    drive_set(s);
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic wait_frames(input int n, input int tmo);
    for (int i = 0; i < tmo && nfr < n; i++) @(negedge clk);
  endtask

  task automatic wait_collect(input int tmo);
    for (int i = 0; i < tmo && !collecting; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    if (cyc == 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bset_t s, sb;
    int n0, s0, r0;
    void'($urandom(32'h5EED));
    rst_n = 0; port_en = 0; sleep_en = 0; div_sel = 2'b01; res_valid = 0;
    set_en(1, 1, 1);
    drive_set(gen_set(0));
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R9: reset state, no activity while disabled
    repeat (50) @(negedge clk);
    chk(!ser_clk && !ser_sync && !ser_data && rise_cnt == 0, "R9 reset quiet",
        FW'({ser_clk, ser_sync, ser_data}), '0);

    // R1 / R3: period per divide code, free-running while idle
    port_en = 1;
    for (int c = 0; c < 4; c++) begin
      div_sel = 2'(c);
      r0 = rise_cnt;
      repeat (60) @(negedge clk);
      chk(last_period == period_of(2'(c)), "R1 serial clock period",
          FW'(last_period), FW'(period_of(2'(c))));
      chk(rise_cnt > r0 + 5, "R3 clock runs while idle", FW'(rise_cnt - r0), FW'(6));
    end

    // R5: full frame, all words
    div_sel = 2'b01;
    n0 = nfr;
    s = gen_set(5);
    send(s);
    wait_frames(n0 + 1, 3000);
    chk(nfr == n0 + 1 && frames[n0] == expect_frame(s, 1, 1, 1), "R5 full frame",
        frames[n0], expect_frame(s, 1, 1, 1));

    // R2: sleep parks the clock when idle
    sleep_en = 1;
    div_sel = 2'b10;
    repeat (20) @(negedge clk);
    r0 = rise_cnt;
    repeat (100) @(negedge clk);
    chk(rise_cnt == r0 && !ser_clk, "R2 parked before data", FW'(rise_cnt - r0), '0);
    n0 = nfr;
    s = gen_set(33);
    send(s);
    wait_frames(n0 + 1, 3000);
    chk(frames[n0] == expect_frame(s, 1, 1, 1), "R2 frame sent in sleep mode",
        frames[n0], expect_frame(s, 1, 1, 1));
    repeat (20) @(negedge clk);
    r0 = rise_cnt;
    repeat (80) @(negedge clk);
    chk(rise_cnt == r0 && !ser_clk, "R2 parked after frame", FW'(rise_cnt - r0), '0);

    // R5: random enable mixes, divides and data
    for (int k = 0; k < 8; k++) begin
      int e;
      e = 1 + int'($urandom % 7);
      set_en(e[0], e[1], e[2]);
      div_sel = 2'($urandom % 4);
      sleep_en = 1'($urandom % 2);
      s = gen_set($urandom % 32'h100000);
      n0 = nfr;
      send(s);
      wait_frames(n0 + 1, 3000);
      chk(nfr == n0 + 1 && frames[n0] == expect_frame(s, e[0], e[1], e[2]),
          "R5 enabled word subset", frames[n0], expect_frame(s, e[0], e[1], e[2]));
    end

    // R8: no words enabled
    sleep_en = 0; div_sel = 2'b01;
    set_en(0, 0, 0);
    s0 = sync_cnt;
    send(gen_set(44));
    repeat (200) @(negedge clk);
    chk(sync_cnt == s0, "R8 no frame without words", FW'(sync_cnt - s0), '0);
    set_en(1, 1, 1);
    repeat (400) @(negedge clk);
    chk(sync_cnt == s0, "R8 set discarded", FW'(sync_cnt - s0), '0);

    // R7: overwrite of the waiting set
    div_sel = 2'b11;
    n0 = nfr;
    s = gen_set(100);
    send(s);
    wait_collect(200);
    send(gen_set(101));
    repeat (5) @(negedge clk);
    sb = gen_set(102);
    send(sb);
    wait_frames(n0 + 2, 4000);
    chk(frames[n0] == expect_frame(s, 1, 1, 1), "R7 current frame intact",
        frames[n0], expect_frame(s, 1, 1, 1));
    chk(frames[n0 + 1] == expect_frame(sb, 1, 1, 1), "R7 newest set sent next",
        frames[n0 + 1], expect_frame(sb, 1, 1, 1));
    repeat (1200) @(negedge clk);
    chk(nfr == n0 + 2, "R7 superseded set never sent", FW'(nfr - n0), FW'(2));

    // R10: strobe on every cycle, so strobes meet frame boundaries
    div_sel = 2'b00;
    set_en(1, 0, 0);
    n0 = nfr;
    for (int k = 200; k < 600; k++) begin
      @(negedge clk);
      drive_set(gen_set(k));
      res_valid = 1'b1;
    end
    @(negedge clk);
    res_valid = 1'b0;
    repeat (300) @(negedge clk);
    begin
      int bad = 0;
      int prev = 0;
      int tag = 0;
      for (int f = n0; f < nfr && f < 64; f++) begin
        tag = int'(frames[f][FW-1 -: 20]);
        if (frames[f] != expect_frame(gen_set(tag), 1, 0, 0)) bad++;
        if (f > n0 && tag <= prev) bad++;
        prev = tag;
      end
      chk(nfr - n0 >= 3, "R10 frames during strobe flood", FW'(nfr - n0), FW'(3));
      chk(bad == 0, "R10 every frame a whole ordered set", FW'(bad), '0);
      chk(tag == 599, "R10 last set delivered", FW'(tag), FW'(599));
    end

    // R4: master enable drop mid-frame
    set_en(1, 1, 1);
    div_sel = 2'b11;
    n0 = nfr;
    send(gen_set(700));
    wait_collect(200);
    repeat (30) @(negedge clk);
    port_en = 0;
    @(negedge clk);
    chk(!ser_clk && !ser_sync && !ser_data, "R4 outputs low when disabled",
        FW'({ser_clk, ser_sync, ser_data}), '0);
    collecting = 0;
    s0 = sync_cnt;
    send(gen_set(701));
    repeat (5) @(negedge clk);
    sleep_en = 1;
    port_en = 1;
    repeat (300) @(negedge clk);
    chk(sync_cnt == s0 && nfr == n0 && !ser_clk, "R4 aborted and strobe ignored",
        FW'(sync_cnt - s0), '0);

    // R6: data and marker steady while the serial clock is high
    chk(r6_viol == 0, "R6 changes only at falling edge", FW'(r6_viol), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule